// File: doc/BRIEF.md
# Partitioned-Address Counting Miss Filter

This block gives an early, address-based answer to the question "is this cache line certainly absent?" It divides a line address (offset bits already removed) into equal-width fields. Each field selects an entry in its own array of small reference counters. Each counter records how many resident cache lines carry that field value. A lookup reports a definite miss when any selected counter is zero. When every selected counter is non-zero it reports "maybe present". The "maybe present" answer can be wrong. The miss answer is never wrong while the counters track the cache contents.

The cache controller drives the update port each time a line is filled. The port carries the fetched line and, when a line was evicted, the victim's address. Counters selected by the fetched line count up. Counters selected by the victim count down. Counters saturate at their maximum and never go below zero. A synchronous reset empties every array, which stands for an empty cache. The cache, its replacement choice and the scheduler that consumes the prediction sit outside this block.

Top module: `partition_miss_filter`

## Requirements
- R1: The line address is split into NPART fields of ADDR_W/NPART bits each. Field k occupies bits [k*FW +: FW] (6 bits at the default settings) and indexes only array k, which has 2^FW counters.
- R2: `lk_miss` is 1 exactly when at least one counter selected by the fields of `lk_line` equals zero. Otherwise it is 0 (maybe present).
- R3: `lk_miss` follows `lk_line` combinationally in the same cycle. An update becomes visible to lookups only after the rising clock edge that samples it.
- R4: While `rst` is high at a rising edge, every counter is cleared, so every lookup reports 1 afterwards.
- R5: An update with `upd_valid`=1 increments the counter that each field of `upd_fill_line` selects. A fill with no victim makes a lookup of that line report 0.
- R6: With `upd_valid`=1 and `upd_victim_valid`=1, the counter that each field of `upd_victim_line` selects is decremented. Evicting the only copy of a line makes its lookup report 1 again.
- R7: With `upd_victim_valid`=0, `upd_victim_line` has no effect on any counter.
- R8: A counter stops at its maximum (15 for 4-bit counters). After 17 fills of one line, that line reports 0 after 14 evictions and 1 after the 15th.
- R9: A counter at zero stays at zero when decremented. Evicting an absent line leaves it reported as a miss, and a later single fill followed by a single eviction returns it to 1.
- R10: When the fill and the victim select the same counter in a field, that counter keeps its value for that update.
- R11: A line that was never filled reports 0 when each of its fields matches the same field of some resident line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, empties all arrays |
| lk_line | input | ADDR_W | Line address to look up |
| lk_miss | output | 1 | 1 = certainly absent, 0 = maybe present |
| upd_valid | input | 1 | Apply an update at this clock edge |
| upd_fill_line | input | ADDR_W | Line address being brought into the cache |
| upd_victim_valid | input | 1 | A victim line was evicted with this fill |
| upd_victim_line | input | ADDR_W | Line address leaving the cache |

## Verification
The bound checker watches four properties on every cycle. The output is never unknown, and the cycle after reset reports a miss. A fill with no victim makes the filled line read as present on the next cycle. With no update pending, the answer changes only when the looked-up address changes. The properties that depend on counter values cannot be seen from the ports in any single cycle, so only the bench's sequences show them. These are saturation at the top, the floor at zero, a fill and victim sharing one counter, and aliasing that yields a false "maybe present". The bench therefore keeps an arithmetic count per field value and compares against it after directed sequences and a long run of colliding updates.

// File: rtl/pmf_pkg.sv
package pmf_pkg;

  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_UP   = 2'd1,
    CNT_DOWN = 2'd2
  } cnt_op_e;

  // Saturating step: stops at all-ones going up and at zero going down.
  function automatic logic [7:0] cnt_step(input logic [7:0] cur,
                                          input logic [7:0] top,
                                          input cnt_op_e    op);
    logic [7:0] nxt;
    nxt = cur;
    case (op)
      CNT_UP:   if (cur != top)   nxt = cur + 8'd1;
      CNT_DOWN: if (cur != 8'd0)  nxt = cur - 8'd1;
      default:  nxt = cur;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/pmf_field_split.sv
module pmf_field_split #(
  parameter int ADDR_W = 24,
  parameter int NPART  = 4,
  localparam int FW    = ADDR_W / NPART
) (
  input  logic [ADDR_W-1:0]         line,
  output logic [NPART-1:0][FW-1:0]  fields
);

  for (genvar k = 0; k < NPART; k++) begin : g_field
    assign fields[k] = line[k*FW +: FW];
  end

endmodule

// File: rtl/pmf_counter_bank.sv
module pmf_counter_bank
  import pmf_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int CNT_W = 4,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_zero,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] inc_idx,
  input  logic             dec_en,
  input  logic [IDX_W-1:0] dec_idx
);

  localparam logic [7:0] CNT_TOP = 8'((1 << CNT_W) - 1);

  logic [CNT_W-1:0] cnt_q [DEPTH];
  logic [CNT_W-1:0] inc_next;
  logic [CNT_W-1:0] dec_next;
  logic             same_slot;

  assign rd_zero   = (cnt_q[rd_idx] == '0);
  assign same_slot = dec_en && (inc_idx == dec_idx);
  assign inc_next  = CNT_W'(cnt_step(8'(cnt_q[inc_idx]), CNT_TOP, CNT_UP));
  assign dec_next  = CNT_W'(cnt_step(8'(cnt_q[dec_idx]), CNT_TOP, CNT_DOWN));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) cnt_q[i] <= '0;
    end else if (upd_en && !same_slot) begin
      cnt_q[inc_idx] <= inc_next;
      if (dec_en) cnt_q[dec_idx] <= dec_next;
    end
  end

endmodule

// File: rtl/partition_miss_filter.sv
module partition_miss_filter #(
  parameter int ADDR_W = 24,
  parameter int NPART  = 4,
  parameter int CNT_W  = 4,
  localparam int FW    = ADDR_W / NPART
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] lk_line,
  output logic              lk_miss,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_fill_line,
  input  logic              upd_victim_valid,
  input  logic [ADDR_W-1:0] upd_victim_line
);

  logic [NPART-1:0][FW-1:0] lk_f;
  logic [NPART-1:0][FW-1:0] fill_f;
  logic [NPART-1:0][FW-1:0] vic_f;
  logic [NPART-1:0]         part_zero;

  pmf_field_split #(.ADDR_W(ADDR_W), .NPART(NPART)) u_split_lk (
    .line(lk_line), .fields(lk_f));
  pmf_field_split #(.ADDR_W(ADDR_W), .NPART(NPART)) u_split_fill (
    .line(upd_fill_line), .fields(fill_f));
  pmf_field_split #(.ADDR_W(ADDR_W), .NPART(NPART)) u_split_vic (
    .line(upd_victim_line), .fields(vic_f));

  for (genvar k = 0; k < NPART; k++) begin : g_bank
    pmf_counter_bank #(.IDX_W(FW), .CNT_W(CNT_W)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .rd_idx  (lk_f[k]),
      .rd_zero (part_zero[k]),
      .upd_en  (upd_valid),
      .inc_idx (fill_f[k]),
      .dec_en  (upd_victim_valid),
      .dec_idx (vic_f[k])
    );
  end

  assign lk_miss = |part_zero;

endmodule

// File: rtl/pmf_checker.sv
module pmf_checker #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] lk_line,
  input logic              lk_miss,
  input logic              upd_valid,
  input logic [ADDR_W-1:0] upd_fill_line,
  input logic              upd_victim_valid,
  input logic [ADDR_W-1:0] upd_victim_line
);

  AST_MISS_KNOWN: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(lk_miss)); // R2

  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> lk_miss); // R4

  AST_FILL_PRESENT: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !upd_victim_valid) |=>
      ((lk_line != $past(upd_fill_line)) || !lk_miss)); // R5

  AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (rst)
    !upd_valid |=> (!$stable(lk_line) || $stable(lk_miss))); // R3

endmodule

bind partition_miss_filter pmf_checker #(.ADDR_W(ADDR_W)) u_pmf_checker (
  .clk              (clk),
  .rst              (rst),
  .lk_line          (lk_line),
  .lk_miss          (lk_miss),
  .upd_valid        (upd_valid),
  .upd_fill_line    (upd_fill_line),
  .upd_victim_valid (upd_victim_valid),
  .upd_victim_line  (upd_victim_line)
);

// File: tb/partition_miss_filter_bench.sv
module partition_miss_filter_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 24;
  localparam int NPART  = 4;
  localparam int CNT_W  = 4;
  localparam int FW     = ADDR_W / NPART;
  localparam int DEPTH  = 1 << FW;
  localparam int TOP    = (1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] lk_line = '0;
  logic              lk_miss;
  logic              upd_valid = 1'b0;
  logic [ADDR_W-1:0] upd_fill_line = '0;
  logic              upd_victim_valid = 1'b0;
  logic [ADDR_W-1:0] upd_victim_line = '0;

  int n_chk = 0;
  int n_bad = 0;
  int mc [NPART][DEPTH];
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  partition_miss_filter #(.ADDR_W(ADDR_W), .NPART(NPART), .CNT_W(CNT_W))
    u_partition_miss_filter (
      .clk(clk), .rst(rst), .lk_line(lk_line), .lk_miss(lk_miss),
      .upd_valid(upd_valid), .upd_fill_line(upd_fill_line),
      .upd_victim_valid(upd_victim_valid), .upd_victim_line(upd_victim_line));

  function automatic logic [ADDR_W-1:0] mk(input int f3, input int f2,
                                           input int f1, input int f0);
    return {FW'(f3), FW'(f2), FW'(f1), FW'(f0)};
  endfunction

  function automatic int fld(input logic [ADDR_W-1:0] a, input int k);
    return int'(a[k*FW +: FW]);
  endfunction

  function automatic logic model_miss(input logic [ADDR_W-1:0] a);
    logic m = 1'b0;
    for (int k = 0; k < NPART; k++) if (mc[k][fld(a, k)] == 0) m = 1'b1;
    return m;
  endfunction

  task automatic check(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: lk_miss actual %b expected %b", req, got, exp);
    end
  endtask

  task automatic look(input string req, input logic [ADDR_W-1:0] a);
    @(negedge clk);
    lk_line = a;
    #1;
    check(req, lk_miss, model_miss(a));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < NPART; k++)
      for (int i = 0; i < DEPTH; i++) mc[k][i] = 0;
  endtask

  task automatic upd(input logic [ADDR_W-1:0] f, input logic vv,
                     input logic [ADDR_W-1:0] v);
    @(negedge clk);
    upd_valid = 1'b1; upd_fill_line = f;
    upd_victim_valid = vv; upd_victim_line = v;
    @(negedge clk);
    upd_valid = 1'b0; upd_victim_valid = 1'b0;
    for (int k = 0; k < NPART; k++) begin
      int fi = fld(f, k);
      int vi = fld(v, k);
      if (!(vv && fi == vi)) begin
        if (mc[k][fi] < TOP) mc[k][fi]++;
        if (vv && mc[k][vi] > 0) mc[k][vi]--;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R4 / R1: every field value of every array is empty after reset
    for (int v = 0; v < DEPTH; v++) look("R4", mk(v, v, v, v));

    // R5 fill visible; R2 one empty field gives miss
    upd(mk(1, 2, 3, 4), 1'b0, '0);
    look("R5", mk(1, 2, 3, 4));
    look("R2", mk(1, 2, 3, 5));
    look("R1", mk(4, 3, 2, 1));
    // R11 aliasing yields maybe present
    upd(mk(9, 9, 9, 9), 1'b0, '0);
    look("R11", mk(1, 9, 3, 9));
    // R7 victim ignored when not valid
    upd(mk(10, 10, 10, 10), 1'b0, mk(1, 2, 3, 4));
    look("R7", mk(1, 2, 3, 4));
    // R6 eviction restores miss
    upd(mk(11, 11, 11, 11), 1'b1, mk(1, 2, 3, 4));
    look("R6", mk(1, 2, 3, 4));
    look("R6", mk(10, 10, 10, 10));
    // R9 floor at zero
    upd(mk(12, 12, 12, 12), 1'b1, mk(20, 20, 20, 20));
    look("R9", mk(20, 20, 20, 20));
    upd(mk(20, 20, 20, 20), 1'b0, '0);
    look("R9", mk(20, 20, 20, 20));
    upd(mk(13, 13, 13, 13), 1'b1, mk(20, 20, 20, 20));
    look("R9", mk(20, 20, 20, 20));
    // R8 saturation
    for (int i = 0; i < 17; i++) upd(mk(30, 31, 32, 33), 1'b0, '0);
    for (int i = 0; i < 14; i++) upd(mk(40, 41, 42, 43), 1'b1, mk(30, 31, 32, 33));
    look("R8", mk(30, 31, 32, 33));
    upd(mk(40, 41, 42, 43), 1'b1, mk(30, 31, 32, 33));
    look("R8", mk(30, 31, 32, 33));

    // R10 shared counter between fill and victim
    do_reset();
    upd(mk(1, 2, 3, 4), 1'b0, '0);
    upd(mk(50, 51, 52, 4), 1'b1, mk(1, 2, 3, 4));
    look("R10", mk(1, 2, 3, 4));
    look("R10", mk(50, 51, 52, 4));
    upd(mk(60, 61, 62, 63), 1'b1, mk(50, 51, 52, 4));
    look("R10", mk(60, 61, 62, 4));

    // R3 combinational lookup, update seen only after the edge
    @(negedge clk);
    lk_line = mk(7, 7, 7, 7);
    upd_valid = 1'b1; upd_fill_line = mk(7, 7, 7, 7); upd_victim_valid = 1'b0;
    #1;
    check("R3", lk_miss, 1'b1);
    @(negedge clk);
    upd_valid = 1'b0;
    for (int k = 0; k < NPART; k++) if (mc[k][7] < TOP) mc[k][7]++;
    #1;
    check("R3", lk_miss, 1'b0);

    // Colliding sweep against the arithmetic count (R2 R5 R6 R8 R9 R10)
    do_reset();
    for (int it = 0; it < 3000; it++) begin
      logic [ADDR_W-1:0] f, v, q;
      f = mk($urandom_range(3), $urandom_range(3), $urandom_range(3), $urandom_range(3));
      v = mk($urandom_range(3), $urandom_range(3), $urandom_range(3), $urandom_range(3));
      q = mk($urandom_range(4), $urandom_range(4), $urandom_range(4), $urandom_range(4));
      upd(f, 1'($urandom_range(1)), v);
      look("R2", q);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule